// File: doc/BRIEF.md
# Thermal watchdog alarm controller

This block sits between the conversion engine of a digital temperature sensor and the over-temperature alarm pin. The engine offers signed temperature samples on a valid/ready stream. The block stores the most recent accepted sample. It compares every accepted sample with two programmable limits: an upper trip limit and a lower release limit. From those comparisons it drives one alarm pin, and software can choose the pin's sense.

Software reaches a configuration register, the two limits and the last sample through a plain parallel register port. The configuration register holds three control bits. The first is a power-down control that stops the sample stream. The second selects between level-style (comparator) and event-style (interrupt) alarm behaviour. The third selects the pin polarity. Reset puts the block in normal operation, with a comparator-mode alarm that is active low. The upper limit resets to 80 °C and the lower limit to 75 °C.

Stream rules: a sample is accepted in any cycle where `smp_valid` and `smp_ready` are both high. `smp_ready` is high exactly while the block is powered up. While the block is in power-down, the engine must hold its sample until `smp_ready` returns, because nothing offered during that time is taken. A sample has no effect on the block until it is accepted.

Top module: `thermal_alarm_ctrl`

## Requirements
- R1: After reset, the configuration reads 0, the upper limit reads 160, the lower limit reads 160 minus 10 (150), the last-sample register reads 0, `alarm_pin` is 1 (inactive, active low) and `smp_ready` is 1.
- R2: A read pulse on `reg_rd` loads `reg_rdata` at the next clock edge. The register map is: address 0 is the last accepted sample (read only, writes to it are ignored); address 1 is the configuration; address 2 is the upper limit; address 3 is the lower limit. Temperatures and limits are 9-bit two's complement values with 0.5 °C per LSB.
- R3: Configuration bit 0 is the power-down control. While it is 1, `smp_ready` is 0, and any sample offered is not accepted: the last-sample register and the alarm pin do not change. Writing 0 restores `smp_ready`.
- R4: In comparator mode (configuration bit 1 = 0), an accepted sample that is strictly greater than the upper limit makes the alarm active. An accepted sample lying between the two limits, inclusive, leaves the alarm unchanged.
- R5: In comparator mode, an accepted sample that is strictly less than the lower limit makes the alarm inactive, unless that sample is also above the upper limit.
- R6: In interrupt mode (configuration bit 1 = 1), the alarm waits first for a sample above the upper limit. When such a sample arrives, the alarm becomes active and the block then waits for a sample below the lower limit, which makes the alarm active again and restores the first wait. A read of any address clears the alarm, and this is the only thing that clears it in interrupt mode.
- R7: In comparator mode, entering power-down leaves the alarm pin at its present level.
- R8: A configuration write that enters power-down with interrupt mode selected makes the alarm inactive at the next edge.
- R9: Configuration bit 2 is the polarity. When it is 1, `alarm_pin` equals the alarm state. When it is 0, `alarm_pin` is the inverse of the alarm state. Changing the polarity does not change the alarm state.
- R10: A configuration write that changes configuration bit 1 makes the alarm inactive, and in interrupt mode the alarm then waits for a sample above the upper limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, restores all defaults |
| smp_valid | input | 1 | Sample offered by the conversion engine |
| smp_ready | output | 1 | Block accepts samples (high when not powered down) |
| smp_data | input | 9 | Signed temperature sample, 0.5 °C per LSB |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 9 | Register write data |
| reg_rdata | output | 9 | Register read data, valid the cycle after the read strobe |
| alarm_pin | output | 1 | Alarm output after the polarity is applied |

## Verification
A wrong alarm state shows on `alarm_pin` one edge after the sample that caused it, because the pin follows the alarm register directly. The bench therefore compares the pin after every sample in sweeps over the whole 9-bit range, in both directions, in each mode and polarity. A limit or configuration bit that is corrupted, or that resets to the wrong value, shows in the readback one cycle after a read. It also moves the point in a sweep where the pin trips. A wrong interrupt wait phase shows as a missing or extra alarm at the next sample that crosses a limit.

// File: rtl/tac_pkg.sv
package tac_pkg;
  typedef enum logic [1:0] {
    ADDR_TEMP = 2'd0,
    ADDR_CFG  = 2'd1,
    ADDR_TOS  = 2'd2,
    ADDR_THY  = 2'd3
  } tac_addr_e;

  localparam int CFG_SD_BIT  = 0;
  localparam int CFG_INT_BIT = 1;
  localparam int CFG_POL_BIT = 2;
  localparam int CFG_BITS    = 3;

  typedef enum logic {
    WAIT_HI = 1'b0,
    WAIT_LO = 1'b1
  } tac_phase_e;
endpackage

// File: rtl/tac_regs.sv
module tac_regs
  import tac_pkg::*;
#(
  parameter int TW      = 9,
  parameter int TOS_RST = 160,
  parameter int THY_RST = 150
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [1:0]    reg_addr,
  input  logic [TW-1:0] reg_wdata,
  input  logic          smp_acc,
  input  logic [TW-1:0] smp_data,
  output logic [TW-1:0] reg_rdata,
  output logic          cfg_sd,
  output logic          cfg_int,
  output logic          cfg_pol,
  output logic [TW-1:0] tos_val,
  output logic [TW-1:0] thy_val,
  output logic          int_sd_enter,
  output logic          mode_flip
);
  localparam logic [TW-1:0] TOS_INIT = TW'(TOS_RST);
  localparam logic [TW-1:0] THY_INIT = TW'(THY_RST);

  logic [TW-1:0] temp_q;
  logic          cfg_wr;

  assign cfg_wr       = reg_wr && (reg_addr == ADDR_CFG);
  assign int_sd_enter = cfg_wr && reg_wdata[CFG_SD_BIT] && !cfg_sd && reg_wdata[CFG_INT_BIT];
  assign mode_flip    = cfg_wr && (reg_wdata[CFG_INT_BIT] != cfg_int);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_sd  <= 1'b0;
      cfg_int <= 1'b0;
      cfg_pol <= 1'b0;
      tos_val <= TOS_INIT;
      thy_val <= THY_INIT;
    end else if (reg_wr) begin
      case (reg_addr)
        ADDR_CFG: begin
          cfg_sd  <= reg_wdata[CFG_SD_BIT];
          cfg_int <= reg_wdata[CFG_INT_BIT];
          cfg_pol <= reg_wdata[CFG_POL_BIT];
        end
        ADDR_TOS: tos_val <= reg_wdata;
        ADDR_THY: thy_val <= reg_wdata;
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       temp_q <= '0;
    else if (smp_acc) temp_q <= smp_data;
  end

  logic [TW-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    case (reg_addr)
      ADDR_TEMP: rd_mux = temp_q;
      ADDR_CFG: begin
        rd_mux[CFG_SD_BIT]  = cfg_sd;
        rd_mux[CFG_INT_BIT] = cfg_int;
        rd_mux[CFG_POL_BIT] = cfg_pol;
      end
      ADDR_TOS: rd_mux = tos_val;
      default:  rd_mux = thy_val;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_mux;
  end
endmodule

// File: rtl/tac_cmp.sv
module tac_cmp #(
  parameter int TW = 9
) (
  input  logic [TW-1:0] smp_data,
  input  logic [TW-1:0] tos_val,
  input  logic [TW-1:0] thy_val,
  output logic          above,
  output logic          below
);
  logic signed [TW-1:0] s_smp, s_tos, s_thy;
  assign s_smp = smp_data;
  assign s_tos = tos_val;
  assign s_thy = thy_val;
  assign above = s_smp > s_tos;
  assign below = s_smp < s_thy;
endmodule

// File: rtl/tac_alarm.sv
module tac_alarm
  import tac_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic smp_acc,
  input  logic above,
  input  logic below,
  input  logic cfg_int,
  input  logic int_sd_enter,
  input  logic mode_flip,
  input  logic rd_clr,
  output logic alarm_st
);
  tac_phase_e phase_q;
  logic       int_event;

  assign int_event = smp_acc && (((phase_q == WAIT_HI) && above) ||
                                 ((phase_q == WAIT_LO) && below));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alarm_st <= 1'b0;
      phase_q  <= WAIT_HI;
    end else if (mode_flip) begin
      alarm_st <= 1'b0;
      phase_q  <= WAIT_HI;
    end else if (int_sd_enter) begin
      alarm_st <= 1'b0;
    end else if (cfg_int) begin
      if (int_event) begin
        alarm_st <= 1'b1;
        phase_q  <= (phase_q == WAIT_HI) ? WAIT_LO : WAIT_HI;
      end else if (rd_clr) begin
        alarm_st <= 1'b0;
      end
    end else if (smp_acc) begin
      if (above)      alarm_st <= 1'b1;
      else if (below) alarm_st <= 1'b0;
    end
  end
endmodule

// File: rtl/thermal_alarm_ctrl.sv
module thermal_alarm_ctrl
  import tac_pkg::*;
#(
  parameter int TW      = 9,
  parameter int TOS_RST = 160,
  parameter int THY_RST = 150
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          smp_valid,
  output logic          smp_ready,
  input  logic [TW-1:0] smp_data,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [1:0]    reg_addr,
  input  logic [TW-1:0] reg_wdata,
  output logic [TW-1:0] reg_rdata,
  output logic          alarm_pin
);
  logic          cfg_sd, cfg_int, cfg_pol;
  logic [TW-1:0] tos_val, thy_val;
  logic          int_sd_enter, mode_flip;
  logic          smp_acc, above, below, alarm_st;

  assign smp_ready = !cfg_sd;
  assign smp_acc   = smp_valid && smp_ready;

  tac_regs #(.TW(TW), .TOS_RST(TOS_RST), .THY_RST(THY_RST)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .smp_acc(smp_acc), .smp_data(smp_data), .reg_rdata(reg_rdata),
    .cfg_sd(cfg_sd), .cfg_int(cfg_int), .cfg_pol(cfg_pol),
    .tos_val(tos_val), .thy_val(thy_val),
    .int_sd_enter(int_sd_enter), .mode_flip(mode_flip)
  );

  tac_cmp #(.TW(TW)) u_cmp (
    .smp_data(smp_data), .tos_val(tos_val), .thy_val(thy_val),
    .above(above), .below(below)
  );

  tac_alarm u_alarm (
    .clk(clk), .rst_n(rst_n), .smp_acc(smp_acc), .above(above), .below(below),
    .cfg_int(cfg_int), .int_sd_enter(int_sd_enter), .mode_flip(mode_flip),
    .rd_clr(reg_rd), .alarm_st(alarm_st)
  );

  assign alarm_pin = cfg_pol ? alarm_st : !alarm_st;
endmodule

// File: rtl/tac_checker.sv
module tac_checker #(
  parameter int TW = 9
) (
  input logic          clk,
  input logic          rst_n,
  input logic          smp_valid,
  input logic          smp_ready,
  input logic [TW-1:0] smp_data,
  input logic          reg_wr,
  input logic          reg_rd,
  input logic [1:0]    reg_addr,
  input logic [TW-1:0] reg_wdata,
  input logic          alarm_pin,
  input logic          alarm_st,
  input logic          cfg_sd,
  input logic          cfg_int,
  input logic [TW-1:0] tos_val,
  input logic [TW-1:0] thy_val
);
  logic acc, cfgw;
  assign acc  = smp_valid && smp_ready;
  assign cfgw = reg_wr && (reg_addr == 2'd1);

  assert_ready_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cfgw && reg_wdata[0] |=> !smp_ready);

  assert_cmp_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    acc && !cfg_int && !reg_wr && ($signed(smp_data) > $signed(tos_val)) |=> alarm_st);

  assert_cmp_clr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    acc && !cfg_int && !reg_wr && ($signed(smp_data) < $signed(thy_val))
    && !($signed(smp_data) > $signed(tos_val)) |=> !alarm_st);

  assert_int_rdclr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_int && reg_rd && !acc && !reg_wr |=> !alarm_st);

  assert_cmp_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_sd && !cfg_int && !reg_wr |=> $stable(alarm_pin));

  assert_sd_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cfgw && reg_wdata[0] && reg_wdata[1] && !cfg_sd && !acc |=> !alarm_st);
endmodule

bind thermal_alarm_ctrl tac_checker #(.TW(TW)) u_chk (.*);

// File: tb/tb_thermal_alarm_ctrl.sv
module tb_thermal_alarm_ctrl;
  localparam int TW = 9;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          smp_valid = 1'b0;
  logic          smp_ready;
  logic [TW-1:0] smp_data = '0;
  logic          reg_wr = 1'b0;
  logic          reg_rd = 1'b0;
  logic [1:0]    reg_addr = '0;
  logic [TW-1:0] reg_wdata = '0;
  logic [TW-1:0] reg_rdata;
  logic          alarm_pin;

  int total = 0;
  int bad = 0;
  bit done = 0;

  // model state
  bit m_sd = 0, m_int = 0, m_pol = 0, m_alarm = 0, m_wait_lo = 0;
  int m_tos = 160, m_thy = 150, m_temp = 0;

  always #10 clk = ~clk;

  thermal_alarm_ctrl dut (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_ready(smp_ready),
    .smp_data(smp_data), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .alarm_pin(alarm_pin)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_pin();
    return m_pol ? int'(m_alarm) : int'(!m_alarm);
  endfunction

  function automatic int sx(input logic [TW-1:0] x);
    return int'($signed(x));
  endfunction

  task automatic wr(input int a, input int d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 2'(a); reg_wdata = TW'(d);
    @(negedge clk);
    reg_wr = 1'b0;
    case (a)
      2: m_tos = sx(TW'(d));
      3: m_thy = sx(TW'(d));
      default: ;
    endcase
  endtask

  task automatic wr_cfg(input bit sd, input bit imode, input bit pol);
    bit flip, enter;
    flip  = (imode != m_int);
    enter = sd && !m_sd && imode;
    wr(1, {sd ? 1 : 0} + (imode ? 2 : 0) + (pol ? 4 : 0));
    if (flip) begin m_alarm = 0; m_wait_lo = 0; end
    else if (enter) m_alarm = 0;
    m_sd = sd; m_int = imode; m_pol = pol;
  endtask

  task automatic rd(input int a, output int d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = 2'(a);
    @(negedge clk);
    reg_rd = 1'b0;
    d = int'(reg_rdata);
    if (m_int) m_alarm = 0;
  endtask

  task automatic push(input int v);
    bit above, below;
    @(negedge clk);
    smp_valid = 1'b1; smp_data = TW'(v);
    @(negedge clk);
    smp_valid = 1'b0;
    if (!m_sd) begin
      m_temp = v & 511;
      above = v > m_tos;
      below = v < m_thy;
      if (m_int) begin
        if ((!m_wait_lo && above) || (m_wait_lo && below)) begin
          m_alarm = 1; m_wait_lo = !m_wait_lo;
        end
      end else if (above) m_alarm = 1;
      else if (below) m_alarm = 0;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 pin", alarm_pin, 1);
    chk("R1 ready", smp_ready, 1);
    rd(1, d); chk("R1 cfg", d, 0);
    rd(2, d); chk("R1 tos", d, 160);
    rd(3, d); chk("R1 thy", d, 150);
    rd(0, d); chk("R1 temp", d, 0);

    // R2 map and read-only sample register
    wr(0, 77); rd(0, d); chk("R2 temp write ignored", d, 0);
    wr(2, 100); rd(2, d); chk("R2 tos readback", d, 100);
    wr(3, 511); rd(3, d); chk("R2 thy readback", d, 511);
    wr(2, 160); wr(3, 150);
    push(-3); rd(0, d); chk("R2 temp after sample", d, (-3) & 511);

    // R4/R5 comparator sweep, both polarities
    for (int p = 0; p < 2; p++) begin
      wr_cfg(0, 0, p[0]);
      for (int v = -256; v < 256; v++) begin
        push(v); chk("R4 cmp rising", alarm_pin, exp_pin());
      end
      for (int v = 255; v >= -256; v--) begin
        push(v); chk("R5 cmp falling", alarm_pin, exp_pin());
      end
    end

    // boundaries, active low
    wr_cfg(0, 0, 0);
    push(0);   chk("R5 base", alarm_pin, 1);
    push(160); chk("R4 equal upper no trip", alarm_pin, 1);
    push(161); chk("R4 above upper trips", alarm_pin, 0);
    push(150); chk("R5 equal lower holds", alarm_pin, 0);
    push(149); chk("R5 below lower releases", alarm_pin, 1);

    // R9 polarity only changes the pin
    push(200);
    wr_cfg(0, 0, 1); chk("R9 pol high pin", alarm_pin, 1);
    wr_cfg(0, 0, 0); chk("R9 pol low pin", alarm_pin, 0);
    push(155); chk("R9 state kept", alarm_pin, 0);

    // R7 and R3: power-down in comparator mode
    wr_cfg(1, 0, 0);
    chk("R7 pin held", alarm_pin, 0);
    chk("R3 ready low", smp_ready, 0);
    push(0); chk("R3 sample ignored pin", alarm_pin, 0);
    rd(0, d); chk("R3 temp unchanged", d, 155);
    wr_cfg(0, 0, 0); chk("R3 ready back", smp_ready, 1);
    push(0); chk("R5 after wake", alarm_pin, 1);

    // R10 mode change clears alarm
    push(200); chk("R4 set before flip", alarm_pin, 0);
    wr_cfg(0, 1, 0); chk("R10 flip clears", alarm_pin, 1);
    push(140); chk("R10 waits for upper", alarm_pin, 1);

    // R6 interrupt sweeps with interleaved reads
    for (int p = 0; p < 2; p++) begin
      wr_cfg(0, 1, p[0]);
      for (int v = -256; v < 256; v++) begin
        push(v); chk("R6 int rising", alarm_pin, exp_pin());
        if ((v % 7) == 0) begin rd(0, d); chk("R6 read clears", alarm_pin, exp_pin()); end
      end
      for (int v = 255; v >= -256; v--) begin
        push(v); chk("R6 int falling", alarm_pin, exp_pin());
        if ((v % 5) == 0) begin rd(1, d); chk("R6 read clears", alarm_pin, exp_pin()); end
      end
    end

    // R6 explicit and R8
    wr_cfg(0, 0, 0); wr_cfg(0, 1, 0);
    push(170); chk("R6 upper event", alarm_pin, 0);
    push(0);   chk("R6 held until read", alarm_pin, 0);
    rd(2, d);  chk("R6 read clears explicit", alarm_pin, 1);
    push(0);   chk("R6 no repeat event", alarm_pin, 1);
    wr_cfg(0, 0, 0); wr_cfg(0, 1, 0);
    push(170); chk("R8 set before", alarm_pin, 0);
    wr_cfg(1, 1, 0);
    chk("R8 entry clears", alarm_pin, 1);
    chk("R3 ready low int", smp_ready, 0);
    wr_cfg(0, 1, 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule